// File: doc/BRIEF.md
# Governed Predicate OR-Inverted Unit with Condition Flags

This block keeps a file of sixteen predicate registers, each holding one bit per byte lane of a vector of `VL` bits. It accepts a 32-bit instruction word with a valid strobe. If the word matches the single supported pattern, the unit reads a governing predicate and two source predicates. In every lane the governor enables, it forms the first source bit ORed with the inverted second source bit. Lanes the governor disables are forced to zero. The result is written to a destination predicate.

In the same clock edge, the unit refreshes four condition flags that summarise the result over the enabled lanes. A word that does not match the pattern is reported as undefined and changes nothing. A separate write port loads predicates directly, and a combinational read port lets any register be observed.

Top module: `predOrnUnit`

## Requirements
- R1: In every lane whose governing bit is 1, the destination bit equals `srcN | ~srcM` for that lane.
- R2: In every lane whose governing bit is 0, the destination bit is written as 0, whatever the source values are.
- R3: `flagN` is the result bit in the lowest-numbered lane whose governing bit is 1.
- R4: `flagZ` is 1 exactly when no enabled lane of the result is 1.
- R5: `flagC` is the inverse of the result bit in the highest-numbered lane whose governing bit is 1.
- R6: `flagV` is always 0.
- R7: When the governing predicate is all zero, the flags become N=0, Z=1 and C=1, and the destination becomes all zero.
- R8: A word is supported when `(instrWord & 32'hFFF0C210) == 32'h25C04010`. The register fields are: second source in bits 19:16, governor in bits 13:10, first source in bits 8:5, and destination in bits 3:0.
- R9: A valid word that is not supported raises `undefInstr` for the one cycle after the edge that sampled it. It leaves every register and all flags unchanged.
- R10: The destination register and the flags both change at the first clock edge after a valid supported word. This latency is the same for all operand values, and the sources are read before that write.
- R11: `wrEn` loads `wrData` into register `wrAddr` at the clock edge. `rdData` shows register `rdAddr` combinationally. If the write port and an instruction target the same register in the same cycle, the instruction result is kept.
- R12: After reset, all registers are zero, the flags are N=0, Z=1, C=1, V=0, and `undefInstr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| instrValid | input | 1 | Instruction word present this cycle |
| instrWord | input | 32 | Instruction word |
| wrEn | input | 1 | Direct predicate write enable |
| wrAddr | input | 4 | Direct write register index |
| wrData | input | VL/8 | Direct write predicate value |
| rdAddr | input | 4 | Read register index |
| rdData | output | VL/8 | Predicate in register `rdAddr` |
| flagN | output | 1 | Result bit in the first enabled lane |
| flagZ | output | 1 | No enabled lane of the result is set |
| flagC | output | 1 | Inverse of the result bit in the last enabled lane |
| flagV | output | 1 | Always zero |
| undefInstr | output | 1 | Previous valid word was unsupported |

## Verification
Every result is due exactly one edge after its stimulus, and this holds for register writes, instruction results, flags and the undefined indication alike. `rdData` then follows combinationally from `rdAddr`. The bench drives inputs on the falling edge, and its reference model updates on the rising edge from those inputs. The comparison happens on the next falling edge, so each check looks at the state produced by exactly one edge. Undefined words are followed by a sweep of all registers through the read port, which confirms that nothing moved.

// File: rtl/predOrnPkg.sv
package predOrnPkg;
  localparam int RegIdxW = 4;
  localparam int NumRegs = 1 << RegIdxW;
  localparam logic [31:0] FixedMask = 32'hFFF0_C210;
  localparam logic [31:0] FixedBits = 32'h25C0_4010;

  typedef struct packed {
    logic                 exec;
    logic                 undef;
    logic [RegIdxW-1:0]   srcN;
    logic [RegIdxW-1:0]   srcM;
    logic [RegIdxW-1:0]   gov;
    logic [RegIdxW-1:0]   dst;
  } ctrlStrobes_t;
endpackage

// File: rtl/predOrnDecode.sv
module predOrnDecode
  import predOrnPkg::*;
(
  input  logic         instrValid,
  input  logic [31:0]  instrWord,
  output ctrlStrobes_t ctrl
);
  logic patternOk;

  assign patternOk = (instrWord & FixedMask) == FixedBits;

  always_comb begin
    ctrl.exec  = instrValid && patternOk;
    ctrl.undef = instrValid && !patternOk;
    ctrl.srcM  = instrWord[19:16];
    ctrl.gov   = instrWord[13:10];
    ctrl.srcN  = instrWord[8:5];
    ctrl.dst   = instrWord[3:0];
  end
endmodule

// File: rtl/predOrnDatapath.sv
module predOrnDatapath
  import predOrnPkg::*;
#(
  parameter int PW = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       ctrl,
  input  logic               wrEn,
  input  logic [RegIdxW-1:0] wrAddr,
  input  logic [PW-1:0]      wrData,
  input  logic [RegIdxW-1:0] rdAddr,
  output logic [PW-1:0]      rdData,
  output logic               flagN,
  output logic               flagZ,
  output logic               flagC,
  output logic               flagV,
  output logic               undefInstr
);
  logic [PW-1:0] predRegs [NumRegs];
  logic [PW-1:0] govMask, opA, opB, laneRes;
  logic          firstBit, lastInvBit;

  assign govMask = predRegs[ctrl.gov];
  assign opA     = predRegs[ctrl.srcN];
  assign opB     = predRegs[ctrl.srcM];

  for (genvar lane = 0; lane < PW; lane++) begin : gLane
    assign laneRes[lane] = govMask[lane] & (opA[lane] | ~opB[lane]);
  end

  // First enabled lane: scan downward so the lowest enabled index wins.
  always_comb begin
    firstBit = 1'b0;
    for (int i = PW - 1; i >= 0; i--) begin
      if (govMask[i]) firstBit = laneRes[i];
    end
  end

  // Last enabled lane: scan upward so the highest enabled index wins.
  always_comb begin
    lastInvBit = 1'b1;
    for (int i = 0; i < PW; i++) begin
      if (govMask[i]) lastInvBit = ~laneRes[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < NumRegs; r++) predRegs[r] <= '0;
    end else begin
      for (int r = 0; r < NumRegs; r++) begin
        if (ctrl.exec && ctrl.dst == RegIdxW'(r)) begin
          predRegs[r] <= laneRes;
        end else if (wrEn && wrAddr == RegIdxW'(r)) begin
          predRegs[r] <= wrData;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagN      <= 1'b0;
      flagZ      <= 1'b1;
      flagC      <= 1'b1;
      flagV      <= 1'b0;
      undefInstr <= 1'b0;
    end else begin
      undefInstr <= ctrl.undef;
      if (ctrl.exec) begin
        flagN <= firstBit;
        flagZ <= ~|laneRes;
        flagC <= lastInvBit;
        flagV <= 1'b0;
      end
    end
  end

  assign rdData = predRegs[rdAddr];
endmodule

// File: rtl/predOrnUnit.sv
module predOrnUnit
  import predOrnPkg::*;
#(
  parameter int VL = 128,
  localparam int PW = VL / 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          instrValid,
  input  logic [31:0]   instrWord,
  input  logic          wrEn,
  input  logic [3:0]    wrAddr,
  input  logic [PW-1:0] wrData,
  input  logic [3:0]    rdAddr,
  output logic [PW-1:0] rdData,
  output logic          flagN,
  output logic          flagZ,
  output logic          flagC,
  output logic          flagV,
  output logic          undefInstr
);
  ctrlStrobes_t ctrl;

  predOrnDecode uDecode (
    .instrValid (instrValid),
    .instrWord  (instrWord),
    .ctrl       (ctrl)
  );

  predOrnDatapath #(.PW(PW)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .rdAddr     (rdAddr),
    .rdData     (rdData),
    .flagN      (flagN),
    .flagZ      (flagZ),
    .flagC      (flagC),
    .flagV      (flagV),
    .undefInstr (undefInstr)
  );
endmodule

// File: rtl/predOrnChecker.sv
module predOrnChecker #(
  parameter int PW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          instrValid,
  input logic [31:0]   instrWord,
  input logic          wrEn,
  input logic [3:0]    rdAddr,
  input logic [PW-1:0] rdData,
  input logic          flagN,
  input logic          flagZ,
  input logic          flagC,
  input logic          flagV,
  input logic          undefInstr
);
  logic wordOk;
  assign wordOk = instrWord[31:20] == 12'h25C && instrWord[15:14] == 2'b01
               && !instrWord[9] && instrWord[4];

  // R6
  flag_v_clear_chk: assert property (@(posedge clk) disable iff (!rstN) !flagV);

  // R4
  zero_blocks_neg_chk: assert property (@(posedge clk) disable iff (!rstN) flagZ |-> !flagN);

  // R9
  undef_raised_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && !wordOk) |=> undefInstr);

  // R9
  undef_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(instrValid && !wordOk) |=> !undefInstr);

  // R9
  undef_flags_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && !wordOk) |=> $stable({flagN, flagZ, flagC}));

  // R11
  idle_read_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !(instrValid && wordOk)) |=> (rdAddr != $past(rdAddr)) || $stable(rdData));
endmodule

bind predOrnUnit predOrnChecker #(.PW(PW)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .instrValid (instrValid),
  .instrWord  (instrWord),
  .wrEn       (wrEn),
  .rdAddr     (rdAddr),
  .rdData     (rdData),
  .flagN      (flagN),
  .flagZ      (flagZ),
  .flagC      (flagC),
  .flagV      (flagV),
  .undefInstr (undefInstr)
);

// File: tb/tb_predOrnUnit.sv
`timescale 1ns/1ps
module tb_predOrnUnit;
  localparam int VL = 128;
  localparam int PW = VL / 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          instrValid = 1'b0;
  logic [31:0]   instrWord = '0;
  logic          wrEn = 1'b0;
  logic [3:0]    wrAddr = '0;
  logic [PW-1:0] wrData = '0;
  logic [3:0]    rdAddr = '0;
  logic [PW-1:0] rdData;
  logic          flagN, flagZ, flagC, flagV, undefInstr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string curTag = "R12";

  // reference state
  logic [PW-1:0] mRegs [16];
  logic mN, mZ, mC, mUndef;

  always #5 clk = ~clk;

  predOrnUnit #(.VL(VL)) dut (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .rdData(rdData), .flagN(flagN), .flagZ(flagZ), .flagC(flagC),
    .flagV(flagV), .undefInstr(undefInstr)
  );

  function automatic logic [31:0] enc(int m, int g, int n, int d);
    return {12'b0010_0101_1100, 4'(m), 2'b01, 4'(g), 1'b0, 4'(n), 1'b1, 4'(d)};
  endfunction

  // behavioural reference, updated on each rising edge
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < 16; r++) mRegs[r] <= '0;
      mN <= 1'b0; mZ <= 1'b1; mC <= 1'b1; mUndef <= 1'b0;
    end else begin
      automatic bit ok = (instrWord & 32'hFFF0_C210) == 32'h25C0_4010;
      automatic logic [PW-1:0] g = mRegs[instrWord[13:10]];
      automatic logic [PW-1:0] a = mRegs[instrWord[8:5]];
      automatic logic [PW-1:0] b = mRegs[instrWord[19:16]];
      automatic logic [PW-1:0] res = '0;
      automatic int first = -1;
      automatic int last = -1;
      mUndef <= instrValid && !ok;
      if (wrEn) mRegs[wrAddr] <= wrData;
      if (instrValid && ok) begin
        for (int e = 0; e < PW; e++) begin
          if (g[e]) begin
            res[e] = a[e] | ~b[e];
            if (first < 0) first = e;
            last = e;
          end
        end
        mRegs[instrWord[3:0]] <= res;
        mN <= (first >= 0) ? res[first] : 1'b0;
        mZ <= (res == '0);
        mC <= (last >= 0) ? ~res[last] : 1'b1;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    if (!done) begin
      chk(curTag, 32'(rdData), 32'(mRegs[rdAddr]));
      chk(rstN ? "R3" : "R12", 32'(flagN), 32'(mN));
      chk(rstN ? "R4" : "R12", 32'(flagZ), 32'(mZ));
      chk(rstN ? "R5" : "R12", 32'(flagC), 32'(mC));
      chk("R6", 32'(flagV), 32'd0);
      chk(rstN ? "R9" : "R12", 32'(undefInstr), 32'(mUndef));
    end
  end

  task automatic idle();
    @(negedge clk);
    instrValid = 1'b0; wrEn = 1'b0;
  endtask

  task automatic load(int a, logic [PW-1:0] v);
    @(negedge clk);
    instrValid = 1'b0; wrEn = 1'b1; wrAddr = 4'(a); wrData = v; rdAddr = 4'(a);
  endtask

  task automatic issue(logic [31:0] w, int view);
    @(negedge clk);
    wrEn = 1'b0; instrValid = 1'b1; instrWord = w; rdAddr = 4'(view);
  endtask

  task automatic sweep(string tag);
    curTag = tag;
    for (int r = 0; r < 16; r++) begin
      @(negedge clk);
      instrValid = 1'b0; wrEn = 1'b0; rdAddr = 4'(r);
    end
  endtask

  initial begin
    curTag = "R12";
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    sweep("R12");

    curTag = "R11";
    load(1, 16'hFFFF);  // governor: all lanes
    load(2, 16'hA5C3);
    load(3, 16'h0F0F);
    load(4, 16'h00F0);  // governor: partial
    load(5, 16'h0000);  // governor: none
    load(6, 16'h0100);  // governor: single lane 8
    load(7, 16'hFFFF);
    idle();

    curTag = "R1";
    issue(enc(3, 1, 2, 8), 8);   // all lanes active
    idle();
    curTag = "R2";
    issue(enc(3, 4, 2, 9), 9);   // partial mask
    idle();
    curTag = "R7";
    issue(enc(3, 5, 2, 10), 10); // empty mask
    idle();
    curTag = "R5";
    issue(enc(2, 6, 3, 11), 11); // single lane
    idle();
    curTag = "R4";
    issue(enc(7, 4, 5, 12), 12); // active lanes all zero
    idle();
    curTag = "R10";
    issue(enc(12, 1, 2, 2), 2);  // destination equals first source
    issue(enc(2, 4, 3, 13), 13); // back-to-back, uses fresh value
    idle();

    curTag = "R11";
    @(negedge clk);              // same-register conflict
    instrValid = 1'b1; instrWord = enc(3, 1, 2, 14);
    wrEn = 1'b1; wrAddr = 4'd14; wrData = 16'h1234; rdAddr = 4'd14;
    @(negedge clk);
    instrValid = 1'b1; instrWord = enc(3, 4, 2, 1);
    wrEn = 1'b1; wrAddr = 4'd15; wrData = 16'h5A5A; rdAddr = 4'd15;
    idle();

    curTag = "R9";
    issue(enc(3, 1, 2, 8) ^ 32'h8000_0000, 8);
    issue(enc(3, 1, 2, 8) ^ 32'h0000_0200, 8);
    issue(enc(3, 1, 2, 8) ^ 32'h0000_0010, 8);
    issue(enc(3, 1, 2, 8) ^ 32'h0000_4000, 8);
    idle();
    sweep("R9");

    curTag = "R8";
    for (int k = 0; k < 6; k++) begin
      issue(enc((k * 5 + 3) % 16, (k * 3 + 1) % 16, (k * 7 + 2) % 16, (k * 11 + 4) % 16),
            (k * 11 + 4) % 16);
    end
    idle();
    sweep("R8");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule